// File: doc/BRIEF.md
# Bridge ADC Serial Reader

This block sits on the host side of a two-wire serial link to a 24-bit bridge-sensor ADC. The converter holds its data line high while no result is waiting. It pulls the line low once a conversion is ready. The reader then drives a clock line. Each positive pulse moves one result bit out of the converter, most significant bit first. After the 24 data bits, the reader sends one, two or three further pulses. The total pulse count tells the converter which input and which gain to use for its next conversion. No command word is sent.

The host supplies a 2-bit mode request. The reader samples it at the start of each read, so a change made during a read only affects the following read. When the last pulse of a read is finished, the reader presents the raw two's-complement word and a 32-bit sign-extended copy. It marks them with a strobe that lasts one system clock cycle. The clock phases come from a divider of the system clock. The default phase length is 250 cycles, which is one microsecond at 250 MHz.

Top module: `bridge_adc_reader`

## Requirements
- R1: During and just after reset, `serClk` is low, `resultValid` is low, and `result` and `resultExt` are zero.
- R2: While the synchronized data line stays high and no read is in progress, `serClk` stays low.
- R3: With the default two synchronizer stages, when `adcData` goes low, `serClk` rises on the third system clock edge after the change. In general this is edge SYNC_STAGES+1.
- R4: During a read, every high phase of `serClk` lasts HALF_PERIOD system clock cycles. Every low phase between two pulses of the same read also lasts HALF_PERIOD cycles. HALF_PERIOD must be at least SYNC_STAGES+2.
- R5: The total pulse count of a read follows the mode latched at its start: `modeReq` 2'b00 gives 25 pulses, 2'b01 gives 26, 2'b10 gives 27, and 2'b11 gives 25. A read never has fewer than 25 or more than 27 pulses.
- R6: The reader samples the data line at the end of each high phase, just before the clock falls. The level sampled at pulse k (k = 1..24) becomes `result[24-k]`, so the first pulse yields bit 23.
- R7: `resultExt[23:0]` equals `result`, and `resultExt[31:24]` repeats `result[23]`.
- R8: `resultValid` is high for exactly one cycle per read. It is registered HALF_PERIOD cycles after the final falling edge of `serClk`, and `result` and `resultExt` carry the new word in that cycle.
- R9: The reader uses the value of `modeReq` at the start of a read for the whole read. A change made during the read decides the pulse count of the next read.
- R10: After a read, a data line that stays low does not start another read. A new read starts only after the line has been seen high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| adcData | input | 1 | Serial data and ready line from the converter (low = ready) |
| modeReq | input | 2 | Channel/gain request for the next read (00:25, 01:26, 10:27, 11:25 pulses) |
| serClk | output | 1 | Serial clock to the converter, idle low |
| result | output | 24 | Latest two's-complement conversion word |
| resultExt | output | 32 | Sign-extended copy of `result` |
| resultValid | output | 1 | One-cycle strobe marking a new result |

## Verification
When the data line falls, the first `serClk` rise is due exactly SYNC_STAGES+1 edges later. After that, every clock phase is due HALF_PERIOD cycles after the previous one, and the bench times each phase with a run-length counter that it samples on the falling clock. The bench models the converter itself. It changes the data line one sample after it sees each rise, and it counts falling edges against the pulse total for the latched mode. The valid strobe, the word and its sign-extended copy are due HALF_PERIOD cycles after the final fall. The bench therefore arms a countdown at that fall and compares the strobe on every cycle, so both an early and a late strobe are caught.

// File: rtl/brd_pkg.sv
package brd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HIGH,
    ST_LOW,
    ST_REARM
  } rdState_t;

  typedef struct packed {
    logic clear;  // start of a read: empty the shift register
    logic shift;  // capture one data bit
    logic done;   // last trailing pulse finished: publish
  } dpCtl_t;

  localparam int PULSE_W = 5;

  function automatic logic [PULSE_W-1:0] pulsesForMode(input logic [1:0] mode);
    case (mode)
      2'b01:   pulsesForMode = 5'd26;
      2'b10:   pulsesForMode = 5'd27;
      default: pulsesForMode = 5'd25;
    endcase
  endfunction

endpackage

// File: rtl/brd_sync.sv
module brd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= '1;
    end else begin
      pipe[0] <= dIn;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dOut = pipe[STAGES-1];

endmodule

// File: rtl/brd_ctrl.sv
module brd_ctrl
  import brd_pkg::*;
#(
  parameter int HALF_PERIOD = 250,
  parameter int DATA_W      = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataSync,
  input  logic [1:0] modeReq,
  output logic       serClk,
  output dpCtl_t     dpCtl
);

  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] PHASE_LAST = CNT_W'(HALF_PERIOD - 1);
  localparam logic [PULSE_W-1:0] DATA_PULSES = PULSE_W'(DATA_W);

  rdState_t            state, nextState;
  logic [CNT_W-1:0]    phaseCnt;
  logic [PULSE_W-1:0]  pulseCnt;
  logic [PULSE_W-1:0]  pulseTarget;
  logic [1:0]          modeLatched;
  logic                phaseEnd;

  assign phaseEnd    = (phaseCnt == PHASE_LAST);
  assign pulseTarget = pulsesForMode(modeLatched);

  always_comb begin
    nextState = state;
    dpCtl     = '0;
    case (state)
      ST_IDLE: begin
        if (!dataSync) begin
          nextState   = ST_HIGH;
          dpCtl.clear = 1'b1;
        end
      end
      ST_HIGH: begin
        if (phaseEnd) begin
          nextState = ST_LOW;
          if (pulseCnt < DATA_PULSES) dpCtl.shift = 1'b1;
        end
      end
      ST_LOW: begin
        if (phaseEnd) begin
          if (pulseCnt == pulseTarget) begin
            nextState  = ST_REARM;
            dpCtl.done = 1'b1;
          end else begin
            nextState = ST_HIGH;
          end
        end
      end
      ST_REARM: begin
        if (dataSync) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      serClk      <= 1'b0;
      phaseCnt    <= '0;
      pulseCnt    <= '0;
      modeLatched <= 2'b00;
    end else begin
      state  <= nextState;
      serClk <= (nextState == ST_HIGH);
      if (nextState != state) begin
        phaseCnt <= '0;
      end else if (state == ST_HIGH || state == ST_LOW) begin
        phaseCnt <= phaseCnt + 1'b1;
      end
      if (state == ST_IDLE && !dataSync) begin
        pulseCnt    <= '0;
        modeLatched <= modeReq;
      end else if (state == ST_HIGH && phaseEnd) begin
        pulseCnt <= pulseCnt + 1'b1;
      end
    end
  end

  // R2: the clock stays low while waiting for a ready indication
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !serClk);

  // R4: a high phase is not cut short
  p_high_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH && !phaseEnd) |=> (state == ST_HIGH && serClk));

  // R5: pulse count within the legal window
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.done |-> (pulseCnt >= 5'd25 && pulseCnt <= 5'd27));

  // R9: the latched mode holds for the whole read
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(modeLatched));

  // R10: a low line after a read does not restart the clock
  p_rearm_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REARM && !dataSync) |=> (state == ST_REARM && !serClk));

endmodule

// File: rtl/brd_datapath.sv
module brd_datapath
  import brd_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int EXT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataSync,
  input  dpCtl_t            dpCtl,
  output logic [DATA_W-1:0] result,
  output logic [EXT_W-1:0]  resultExt,
  output logic              resultValid
);

  localparam int SHC_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shiftReg;
  logic [SHC_W-1:0]  shiftsSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      shiftsSeen  <= '0;
      result      <= '0;
      resultExt   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= dpCtl.done;
      if (dpCtl.clear) begin
        shiftReg   <= '0;
        shiftsSeen <= '0;
      end else if (dpCtl.shift) begin
        shiftReg   <= {shiftReg[DATA_W-2:0], dataSync};
        shiftsSeen <= shiftsSeen + 1'b1;
      end
      if (dpCtl.done) begin
        result    <= shiftReg;
        resultExt <= {{(EXT_W-DATA_W){shiftReg[DATA_W-1]}}, shiftReg};
      end
    end
  end

  // R6: exactly DATA_W bits captured before publishing
  p_shift_total_r6: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.done |-> (shiftsSeen == SHC_W'(DATA_W)));

  // R7: the wide copy agrees with the narrow word
  p_sign_ext_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (resultExt[DATA_W-1:0] == result &&
                     resultExt[EXT_W-1:DATA_W] == {(EXT_W-DATA_W){result[DATA_W-1]}}));

  // R8: single-cycle strobe
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

endmodule

// File: rtl/bridge_adc_reader.sv
module bridge_adc_reader
  import brd_pkg::*;
#(
  parameter int HALF_PERIOD = 250,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 24,
  parameter int EXT_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcData,
  input  logic [1:0]        modeReq,
  output logic              serClk,
  output logic [DATA_W-1:0] result,
  output logic [EXT_W-1:0]  resultExt,
  output logic              resultValid
);

  logic   dataSync;
  dpCtl_t dpCtl;

  brd_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (adcData),
    .dOut (dataSync)
  );

  brd_ctrl #(.HALF_PERIOD(HALF_PERIOD), .DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .dataSync (dataSync),
    .modeReq  (modeReq),
    .serClk   (serClk),
    .dpCtl    (dpCtl)
  );

  brd_datapath #(.DATA_W(DATA_W), .EXT_W(EXT_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .dataSync    (dataSync),
    .dpCtl       (dpCtl),
    .result      (result),
    .resultExt   (resultExt),
    .resultValid (resultValid)
  );

endmodule

// File: tb/bridge_adc_reader_test.sv
`timescale 1ns/1ps
module bridge_adc_reader_test;

  localparam int HALF = 5;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adcData = 1'b1;
  logic [1:0]  modeReq = 2'b00;
  logic        serClk;
  logic [23:0] result;
  logic [31:0] resultExt;
  logic        resultValid;

  bridge_adc_reader #(.HALF_PERIOD(HALF), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rstN(rstN), .adcData(adcData), .modeReq(modeReq),
    .serClk(serClk), .result(result), .resultExt(resultExt),
    .resultValid(resultValid)
  );

  always #2 clk = ~clk;

  int testCount = 0;
  int failCount = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pulsesOf(input logic [1:0] m);
    if (m == 2'b01) return 26;
    if (m == 2'b10) return 27;
    return 25;
  endfunction

  // converter model and per-clock reference
  int          pulseNum = 0;
  int          fallNum = 0;
  int          expPulses = 25;
  int          vCnt = 0;
  int          runLen = 0;
  bit          holdLow = 0;
  bit          expValid;
  logic        prevSer = 1'b0;
  logic [23:0] adcWord = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (vCnt > 0) begin
        vCnt--;
        expValid = (vCnt == 0);
      end else begin
        expValid = 0;
      end
      check(resultValid == expValid, "R8", "valid strobe timing", resultValid, expValid);
      if (expValid) begin
        check(result == adcWord, "R6", "captured word", result, adcWord);
        check(resultExt == {{8{adcWord[23]}}, adcWord}, "R7", "sign extension",
              resultExt, {{8{adcWord[23]}}, adcWord});
        check(pulseNum == expPulses, "R5", "pulse total at valid", pulseNum, expPulses);
      end
      if (serClk && !prevSer) begin
        if (pulseNum >= 1) check(runLen == HALF, "R4", "low phase length", runLen, HALF);
        pulseNum++;
        if (pulseNum <= 24) adcData = adcWord[24-pulseNum];
        else if (pulseNum == 25) adcData = holdLow ? 1'b0 : 1'b1;
        runLen = 1;
      end else if (!serClk && prevSer) begin
        check(runLen == HALF, "R4", "high phase length", runLen, HALF);
        fallNum++;
        if (fallNum == expPulses) vCnt = HALF;
        runLen = 1;
      end else begin
        runLen++;
      end
      prevSer = serClk;
    end
  end

  task automatic readOnce(input logic [23:0] word, input logic [1:0] mode,
                          input bit doMid, input logic [1:0] midMode, input bit lowAfter);
    int n;
    adcWord   = word;
    holdLow   = lowAfter;
    pulseNum  = 0;
    fallNum   = 0;
    expPulses = pulsesOf(mode);
    modeReq   = mode;
    @(negedge clk);
    adcData = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!serClk && n < 50);
    check(n == SYNC + 1, "R3", "start latency", n, SYNC + 1);
    if (doMid) modeReq = midMode;
    while (!resultValid) @(negedge clk);
    repeat (4 * HALF) @(negedge clk);
    check(pulseNum == expPulses, "R5", "no extra pulses", pulseNum, expPulses);
    check(serClk == 1'b0, "R5", "clock idle after read", serClk, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int highSeen;
    repeat (3) @(negedge clk);
    check(serClk == 0, "R1", "serClk in reset", serClk, 0);
    check(resultValid == 0, "R1", "valid in reset", resultValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(result == 0, "R1", "result after reset", result, 0);
    check(resultExt == 0, "R1", "resultExt after reset", resultExt, 0);

    // R2: idle line high, no clock
    highSeen = 0;
    repeat (60) begin
      @(negedge clk);
      if (serClk) highSeen++;
    end
    check(highSeen == 0, "R2", "clock while idle", highSeen, 0);

    // R5/R6/R7: every mode, assorted words incl. saturation codes
    readOnce(24'h123456, 2'b00, 0, 2'b00, 0);
    readOnce(24'h800000, 2'b01, 0, 2'b00, 0);
    readOnce(24'h7FFFFF, 2'b10, 0, 2'b00, 0);
    readOnce(24'hA5C3F0, 2'b11, 0, 2'b00, 0);
    readOnce(24'hFFFFFF, 2'b00, 0, 2'b00, 0);
    readOnce(24'h000001, 2'b10, 0, 2'b00, 0);

    // R9: change request during a read; it applies to the next read
    readOnce(24'h5A5A5A, 2'b01, 1, 2'b10, 0);
    expPulses = 27;
    readOnce(24'h0F0F0F, 2'b10, 0, 2'b00, 0);

    // R10: line stays low after a read
    readOnce(24'h3C3C3C, 2'b00, 0, 2'b00, 1);
    highSeen = 0;
    repeat (20 * HALF) begin
      @(negedge clk);
      if (serClk) highSeen++;
    end
    check(highSeen == 0, "R10", "restart on stale low", highSeen, 0);
    check(pulseNum == 25, "R10", "pulse count unchanged", pulseNum, 25);
    adcData = 1'b1;
    repeat (6) @(negedge clk);
    readOnce(24'hC00001, 2'b01, 0, 2'b00, 0);

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule